// File: doc/BRIEF.md
# Receive Cell Port with Word Parity Check

This block is the receive half of a cell bus master. After a physical-layer device has been selected elsewhere, the block opens the bus with a pull enable. It waits for a word flagged as the start of a cell and then counts a fixed number of words into a one-cell buffer. Every word arrives with a parity bit, and the block checks odd parity across the data lines and that bit.

A cell that is complete and clean is replayed downstream as a contiguous burst of words. The first and last words of the burst are marked. A cell is discarded if parity checking is on and any of its words fails. A cell is also discarded if a new start-of-cell cuts it short. Each discarded cell raises a one-cycle pulse for an external statistics counter.

The bus is 8 or 16 bits wide. In the wide mode the most significant byte of each word is the earlier byte of the cell. The spare byte that fills out the final word of an odd-length cell is not passed on.

Top module: `cell_rx_port`

## Requirements
- R1: A word on the device pins is taken at the rising edge that ends the cycle after a cycle in which `pull_en` was high. No word is taken otherwise.
- R2: A cell begins only on a taken word with `phy_soc` high. Taken words with `phy_soc` low, while no cell is in progress, produce no output and no drop pulse.
- R3: A cell is WORDS words long. WORDS equals CELL_BYTES when BUS_W is 8 and (CELL_BYTES+1)/2 when BUS_W is 16, so with the default 53 bytes a 16-bit cell is 27 words. Each output burst is exactly WORDS words long.
- R4: A word passes the parity check when the total number of ones in its data bits and `phy_par` is odd. An all-zero data word is good only with `phy_par` = 1.
- R5: When `par_chk_en` is 1 and any word of a cell fails parity, nothing of that cell is output and `drop_pulse` is high for exactly one cycle.
- R6: When `par_chk_en` is 0, a full-length cell is delivered unchanged whatever its parity bits are.
- R7: A taken word with `phy_soc` high that arrives while a cell is in progress discards the partial cell with one `drop_pulse` cycle. That word then starts a new cell, which is counted from one.
- R8: Output starts only after the last word of the cell has been taken and checked. The burst has `out_valid` high on WORDS consecutive cycles, with `out_first` on the first word only and `out_last` on the last word only.
- R9: While a burst is being output, `pull_en` stays low on every burst cycle except the one carrying `out_last`.
- R10: In 16-bit mode with an odd CELL_BYTES, the low byte (bits 7:0) of the final output word is zero. The other words appear exactly as received.
- R11: After reset, `pull_en` is 1 and both `out_valid` and `drop_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; all pins sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| par_chk_en | input | 1 | 1 discards cells with a parity failure |
| phy_data | input | BUS_W | Data word from the device; top bit is the earlier byte |
| phy_soc | input | 1 | High with the first word of a cell |
| phy_par | input | 1 | Odd parity bit over `phy_data` |
| pull_en | output | 1 | Asks the device to present a word on the next cycle |
| out_valid | output | 1 | Output word valid |
| out_data | output | BUS_W | Output word |
| out_first | output | 1 | First word of a delivered cell |
| out_last | output | 1 | Last word of a delivered cell |
| drop_pulse | output | 1 | One cycle per discarded cell |

## Verification
Plain back-to-back clean cells check the counting and the release timing against the scoreboard. Leading words with no start marker show that hunting ignores them. Cells made of alternating all-zero and all-one words test the parity rule itself, because zero data needs the parity bit set. Single bad-parity words are placed first, in the middle and last, once with checking on and once off, which separates discard-on-error from pass-through. The last-word case also shows that nothing is released early. Short cells cut off by a fresh start marker, down to one word and to one word short of full, test the restart path and the drop pulse count.

// File: rtl/cell_rx_pkg.sv
`timescale 1ns/1ps
package cell_rx_pkg;

   typedef enum logic [1:0] {
      FR_HUNT = 2'd0,
      FR_FILL = 2'd1,
      FR_HOLD = 2'd2
   } fr_state_t;

   // words per cell for a given bus width and byte count
   function automatic int cell_words(input int bus_w, input int bytes);
      if (bus_w == 16)
         return (bytes + 1) / 2;
      return bytes;
   endfunction

endpackage

// File: rtl/cell_rx_parity.sv
`timescale 1ns/1ps
module cell_rx_parity #(
   parameter int BUS_W = 16
) (
   input  logic [BUS_W-1:0] data,
   input  logic             par,
   output logic             ok
);
   generate
      if (BUS_W == 16) begin : g_two_lane
         logic hi_x, lo_x;
         assign hi_x = ^data[15:8];
         assign lo_x = ^data[7:0];
         assign ok   = hi_x ^ lo_x ^ par;
      end else begin : g_one_lane
         assign ok = (^data) ^ par;
      end
   endgenerate
endmodule

// File: rtl/cell_rx_framer.sv
`timescale 1ns/1ps
module cell_rx_framer
   import cell_rx_pkg::*;
#(
   parameter int BUS_W = 16,
   parameter int WORDS = 27,
   parameter int AW    = 5,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             par_chk_en,
   input  logic [BUS_W-1:0] phy_data,
   input  logic             phy_soc,
   input  logic             word_ok,
   input  logic             drain_end,
   output logic             pull_en,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output logic [BUS_W-1:0] wr_data,
   output logic             release_cell,
   output logic             drop_pulse
);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORDS - 1);

   fr_state_t        st;
   logic [CNT_W-1:0] cnt;
   logic             bad;
   logic             take;
   logic             word_bad;
   logic             last_pending;

   assign take         = pull_en_q;
   assign word_bad     = par_chk_en & ~word_ok;
   assign last_pending = (st == FR_FILL) && (cnt == LAST_IDX) && pull_en_q;

   logic pull_en_q;

   // close the bus one cycle early so no word is in flight once the cell is full
   always_comb begin
      pull_en = (st != FR_HOLD) && !last_pending;
   end

   always_comb begin
      wr_en   = take && (phy_soc || (st == FR_FILL));
      wr_addr = phy_soc ? '0 : cnt[AW-1:0];
      wr_data = phy_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st           <= FR_HUNT;
         cnt          <= '0;
         bad          <= 1'b0;
         pull_en_q    <= 1'b0;
         release_cell <= 1'b0;
         drop_pulse   <= 1'b0;
      end else begin
         release_cell <= 1'b0;
         drop_pulse   <= 1'b0;
         pull_en_q    <= pull_en;
         case (st)
            FR_HOLD: begin
               if (drain_end) st <= FR_HUNT;
            end
            default: begin
               if (take) begin
                  if (phy_soc) begin
                     if (st == FR_FILL) drop_pulse <= 1'b1;
                     st  <= FR_FILL;
                     cnt <= CNT_W'(1);
                     bad <= word_bad;
                  end else if (st == FR_FILL) begin
                     if (cnt == LAST_IDX) begin
                        cnt <= '0;
                        if (bad || word_bad) begin
                           drop_pulse <= 1'b1;
                           st         <= FR_HUNT;
                        end else begin
                           release_cell <= 1'b1;
                           st           <= FR_HOLD;
                        end
                     end else begin
                        cnt <= cnt + CNT_W'(1);
                        bad <= bad | word_bad;
                     end
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/cell_rx_buffer.sv
`timescale 1ns/1ps
module cell_rx_buffer #(
   parameter int BUS_W    = 16,
   parameter int WORDS    = 27,
   parameter int AW       = 5,
   parameter bit PAD_LAST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [BUS_W-1:0] wr_data,
   input  logic             release_cell,
   output logic             drain_end,
   output logic             out_valid,
   output logic [BUS_W-1:0] out_data,
   output logic             out_first,
   output logic             out_last
);
   localparam logic [AW-1:0] LAST_ADDR = AW'(WORDS - 1);

   logic [BUS_W-1:0] mem [WORDS];
   logic             draining;
   logic [AW-1:0]    rd;
   logic [AW-1:0]    rd_sel;
   logic [BUS_W-1:0] rd_word;
   logic [BUS_W-1:0] shaped;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_sel    = draining ? rd : '0;
   assign rd_word   = mem[rd_sel];
   assign drain_end = draining && (rd == LAST_ADDR);

   generate
      if (PAD_LAST) begin : g_pad
         always_comb begin
            shaped = rd_word;
            if (rd_sel == LAST_ADDR) shaped[BUS_W/2-1:0] = '0;
         end
      end else begin : g_nopad
         assign shaped = rd_word;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         draining  <= 1'b0;
         rd        <= '0;
         out_valid <= 1'b0;
         out_first <= 1'b0;
         out_last  <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= 1'b0;
         out_first <= 1'b0;
         out_last  <= 1'b0;
         if (release_cell) begin
            out_valid <= 1'b1;
            out_first <= 1'b1;
            out_data  <= shaped;
            rd        <= AW'(1);
            draining  <= 1'b1;
         end else if (draining) begin
            out_valid <= 1'b1;
            out_data  <= shaped;
            if (rd == LAST_ADDR) begin
               out_last <= 1'b1;
               draining <= 1'b0;
            end else begin
               rd <= rd + AW'(1);
            end
         end
      end
   end
endmodule

// File: rtl/cell_rx_port.sv
`timescale 1ns/1ps
module cell_rx_port
   import cell_rx_pkg::*;
#(
   parameter int BUS_W      = 16,
   parameter int CELL_BYTES = 53
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             par_chk_en,
   input  logic [BUS_W-1:0] phy_data,
   input  logic             phy_soc,
   input  logic             phy_par,
   output logic             pull_en,
   output logic             out_valid,
   output logic [BUS_W-1:0] out_data,
   output logic             out_first,
   output logic             out_last,
   output logic             drop_pulse
);
   localparam int WORDS    = cell_words(BUS_W, CELL_BYTES);
   localparam int AW       = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int CNT_W    = $clog2(WORDS + 1);
   localparam bit PAD_LAST = (BUS_W == 16) && ((CELL_BYTES % 2) == 1);

   generate
      if (!(BUS_W == 8 || BUS_W == 16)) begin : g_bad_width
         $error("cell_rx_port: BUS_W must be 8 or 16");
      end
      if (CELL_BYTES < 4) begin : g_bad_len
         $error("cell_rx_port: CELL_BYTES must be at least 4");
      end
   endgenerate

   logic             word_ok;
   logic             drain_end;
   logic             wr_en;
   logic [AW-1:0]    wr_addr;
   logic [BUS_W-1:0] wr_data;
   logic             release_cell;

   cell_rx_parity #(.BUS_W(BUS_W)) u_par (
      .data (phy_data),
      .par  (phy_par),
      .ok   (word_ok)
   );

   cell_rx_framer #(
      .BUS_W (BUS_W),
      .WORDS (WORDS),
      .AW    (AW),
      .CNT_W (CNT_W)
   ) u_frm (
      .clk          (clk),
      .rst_n        (rst_n),
      .par_chk_en   (par_chk_en),
      .phy_data     (phy_data),
      .phy_soc      (phy_soc),
      .word_ok      (word_ok),
      .drain_end    (drain_end),
      .pull_en      (pull_en),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .release_cell (release_cell),
      .drop_pulse   (drop_pulse)
   );

   cell_rx_buffer #(
      .BUS_W    (BUS_W),
      .WORDS    (WORDS),
      .AW       (AW),
      .PAD_LAST (PAD_LAST)
   ) u_buf (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .release_cell (release_cell),
      .drain_end    (drain_end),
      .out_valid    (out_valid),
      .out_data     (out_data),
      .out_first    (out_first),
      .out_last     (out_last)
   );
endmodule

// File: rtl/cell_rx_port_chk.sv
`timescale 1ns/1ps
module cell_rx_port_chk
   import cell_rx_pkg::*;
#(
   parameter int BUS_W      = 16,
   parameter int CELL_BYTES = 53
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pull_en,
   input logic             out_valid,
   input logic [BUS_W-1:0] out_data,
   input logic             out_first,
   input logic             out_last
);
   localparam int WORDS = cell_words(BUS_W, CELL_BYTES);
   localparam int RW    = $clog2(WORDS + 1);

   logic [RW-1:0] run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) run_cnt <= '0;
      else if (out_valid) run_cnt <= out_last ? '0 : run_cnt + RW'(1);
   end

   p_enb_low_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |-> !pull_en);

   p_rise_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> out_first);

   p_run_contig_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |=> (out_valid && !out_first));

   p_marks_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_first || out_last) |-> out_valid);

   p_first_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_first |-> (run_cnt == '0));

   p_last_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> (run_cnt == RW'(WORDS - 1)));

   generate
      if (BUS_W == 16 && (CELL_BYTES % 2) == 1) begin : g_pad_chk
         p_pad_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            out_last |-> (out_data[7:0] == 8'h00));
      end
   endgenerate
endmodule

bind cell_rx_port cell_rx_port_chk #(
   .BUS_W      (BUS_W),
   .CELL_BYTES (CELL_BYTES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pull_en   (pull_en),
   .out_valid (out_valid),
   .out_data  (out_data),
   .out_first (out_first),
   .out_last  (out_last)
);

// File: tb/tb_cell_rx_port.sv
`timescale 1ns/1ps
module tb_cell_rx_port;
   localparam int BW  = 16;
   localparam int CB  = 53;
   localparam int NW  = (CB + 1) / 2;
   localparam bit PAD = (BW == 16) && ((CB % 2) == 1);

   typedef struct {
      logic          soc;
      logic [BW-1:0] d;
      logic          bad;
   } phy_w_t;

   typedef struct {
      logic [BW-1:0] d;
      logic          first;
      logic          last;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          par_chk_en = 1'b1;
   logic [BW-1:0] phy_data = '0;
   logic          phy_soc = 1'b0;
   logic          phy_par = 1'b0;
   logic          pull_en;
   logic          out_valid;
   logic [BW-1:0] out_data;
   logic          out_first;
   logic          out_last;
   logic          drop_pulse;

   phy_w_t phy_q[$];
   exp_t   exp_q[$];
   int     total = 0;
   int     bad = 0;
   int     drops = 0;
   int     exp_drops = 0;
   logic   en_seen = 1'b0;

   always #2.5 clk = ~clk;

   cell_rx_port #(.BUS_W(BW), .CELL_BYTES(CB)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .par_chk_en (par_chk_en),
      .phy_data   (phy_data),
      .phy_soc    (phy_soc),
      .phy_par    (phy_par),
      .pull_en    (pull_en),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .out_first  (out_first),
      .out_last   (out_last),
      .drop_pulse (drop_pulse)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // device model: a grant seen at one edge is answered with a word for the next edge (R1)
   always @(posedge clk) en_seen <= rst_n ? pull_en : 1'b0;

   always @(negedge clk) begin
      if (en_seen) begin
         if (phy_q.size() > 0) begin
            phy_w_t w;
            w = phy_q.pop_front();
            phy_data <= w.d;
            phy_soc  <= w.soc;
            phy_par  <= (~^w.d) ^ w.bad;
         end else begin
            phy_data <= 16'h5A3C;
            phy_soc  <= 1'b0;
            phy_par  <= 1'b0;
         end
      end
   end

   // monitor and scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (drop_pulse) drops++;
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check("R8 unexpected output word", {16'h0, out_data}, 32'hFFFF_FFFF);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check("R1/R3/R10 data", {16'h0, out_data}, {16'h0, e.d});
               check("R8 first mark", {31'h0, out_first}, {31'h0, e.first});
               check("R8 last mark", {31'h0, out_last}, {31'h0, e.last});
            end
            if (!out_last) check("R9 pull_en low in burst", {31'h0, pull_en}, 32'h0);
         end
      end
   end

   function automatic logic [BW-1:0] pat(int id, int i, int kind);
      if (kind == 1) return i[0] ? '1 : '0;
      return BW'(id * 1031 + i * 77 + 3);
   endfunction

   task automatic send_cell(int id, int n, int bad_at, int kind);
      bit drop;
      drop = (n != NW) || (par_chk_en && bad_at >= 0);
      for (int i = 0; i < n; i++) begin
         phy_w_t w;
         exp_t   e;
         w.soc = (i == 0);
         w.d   = pat(id, i, kind);
         w.bad = (i == bad_at);
         phy_q.push_back(w);
         if (!drop) begin
            e.d = w.d;
            if (PAD && i == NW - 1) e.d[7:0] = 8'h00;
            e.first = (i == 0);
            e.last  = (i == NW - 1);
            exp_q.push_back(e);
         end
      end
      if (drop) exp_drops++;
   endtask

   task automatic send_idle(int n);
      for (int i = 0; i < n; i++) begin
         phy_w_t w;
         w.soc = 1'b0;
         w.d   = BW'(16'hA5A5 ^ i);
         w.bad = 1'b0;
         phy_q.push_back(w);
      end
   endtask

   task automatic settle(string req);
      for (int i = 0; i < 6000 && (phy_q.size() > 0 || exp_q.size() > 0); i++)
         @(posedge clk);
      repeat (NW * 2 + 8) @(posedge clk);
      @(negedge clk);
      check({req, " words left"}, exp_q.size(), 0);
      check({req, " drop count"}, drops, exp_drops);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 pull_en after reset", {31'h0, pull_en}, 32'h1);
      check("R11 out_valid after reset", {31'h0, out_valid}, 32'h0);
      check("R11 drop_pulse after reset", {31'h0, drop_pulse}, 32'h0);

      // R2: words without start marker are ignored, then a clean cell
      send_idle(6);
      send_cell(1, NW, -1, 0);
      settle("R2");

      // R3 R1 R10: back-to-back clean cells
      send_cell(2, NW, -1, 0);
      send_cell(3, NW, -1, 0);
      send_cell(4, NW, -1, 0);
      settle("R3");

      // R4: zero and all-ones words need the right odd parity bit
      send_cell(5, NW, -1, 1);
      settle("R4");

      // R5: parity failures with checking on, first / middle / last word
      send_cell(6, NW, 13, 0);
      settle("R5 middle");
      send_cell(7, NW, 0, 1);
      send_cell(8, NW, NW - 1, 0);
      send_cell(9, NW, -1, 0);
      settle("R5 first and last");

      // R6: checking off lets bad parity through
      par_chk_en = 1'b0;
      send_cell(10, NW, 5, 0);
      send_cell(11, NW, NW - 1, 1);
      settle("R6");
      par_chk_en = 1'b1;

      // R7: cut-short cells restart on the new start marker
      send_cell(12, 10, -1, 0);
      send_cell(13, NW, -1, 0);
      settle("R7 ten words");
      send_cell(14, NW - 1, -1, 0);
      send_cell(15, NW, -1, 0);
      settle("R7 one short");
      send_cell(16, 1, -1, 0);
      send_cell(17, 1, -1, 0);
      send_cell(18, NW, -1, 1);
      settle("R7 single words");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule